// File: doc/BRIEF.md
# Four-Core Snooping Write-Through Coherence Subsystem

This block joins four processor ports to one shared word-addressed memory. Each port has a small private direct-mapped cache holding one data word per line, and all caches share one inter-core bus that reaches the memory. The caches are write-through: every write goes over the bus and updates memory in the same cycle. Every cache watches the bus for writes issued by the other ports. The `mode_upd` input picks how a cache reacts when a peer writes a word it holds. In invalidate mode it drops its copy. In update mode it takes the new value and keeps the copy valid.

A port raises `req_valid` and holds its command, address and write data steady until `req_ready` is high in a cycle. It then drops the request after that clock edge. A read that hits its own cache completes in the cycle it is presented, without the bus. A read miss and every write must first win the round-robin bus arbiter, and the transaction completes in the cycle of the grant. The net result is that all four ports see memory as one consistent array.

Top module: `coh_subsys`

## Requirements
- R1: After a synchronous reset every memory word reads 0 and every cache is empty, so no stale word from before the reset is ever returned; `req_ready` stays low while no request is raised.
- R2: A write completes (`req_ready` high) only in a cycle where its port owns the bus. From the next cycle on, memory holds the value, and every later read by any port returns it.
- R3: Line placement uses the address: line index is `addr[INDEX_W-1:0]` and the tag is the upper bits. A read miss takes the bus, returns the memory word and fills the line. A write miss updates memory only and does not allocate a line.
- R4: With `mode_upd`=0 (invalidate), a write by one port clears the copy in every other cache that holds that address. That port's next read of the address misses and must compete for the bus.
- R5: With `mode_upd`=1 (update), a write by one port overwrites the copy in every other cache that holds that address and leaves it valid. That port's next read is a local hit returning the new value.
- R6: A read hit completes in the cycle it is presented, without a bus request, even while another port owns the bus.
- R7: At most one bus transaction runs per cycle. The bus is granted only to a requesting port, and never left idle while a request waits. After port g is granted, priority runs g+1, g+2, and so on, cyclically.
- R8: When a peer write to a line and a local read of that same line fall in one cycle, the snoop takes effect first. In invalidate mode the read does not complete that cycle and is served later from memory with the new value. In update mode the read completes that cycle with the new value.
- R9: A peer write to an address that shares a line index but has a different tag leaves the local line valid and unchanged.
- R10: Under random interleaved reads and writes from all four ports in either mode, every read returns the value of the most recent write completed on the bus to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_upd | input | 1 | 0 = invalidate peers on write, 1 = update peers on write |
| req_valid | input | NCORE | Per-port request, held until ready |
| req_write | input | NCORE | Per-port command: 1 = write, 0 = read |
| req_addr | input | NCORE*ADDR_W | Per-port word address, port i at bits [i*ADDR_W +: ADDR_W] |
| req_wdata | input | NCORE*DATA_W | Per-port write data, port i at bits [i*DATA_W +: DATA_W] |
| req_ready | output | NCORE | Per-port completion strobe, one cycle |
| rsp_rdata | output | NCORE*DATA_W | Per-port read data, valid while req_ready is high for a read |

## Verification
A cache that keeps a copy it should have dropped, or refreshes one it should have left alone, returns a wrong read value the first time that port reads the address again. A flat reference array therefore catches it on that very completion. A wrong valid bit that still yields correct data shows up only as timing. For that reason, the directed cases set the arbiter's rotation so that a port which should miss loses the bus by exactly one cycle, while a port which should hit completes at once. An arbiter fault shows up as a wrong completion order among four simultaneous writes.

// File: rtl/coh_pkg.sv
// Shared types for the snooping coherence subsystem.
// Assumes: nothing; pure type definitions.
package coh_pkg;
    typedef enum logic {
        MODE_INV = 1'b0,
        MODE_UPD = 1'b1
    } coh_mode_e;
endpackage

// File: rtl/coh_rr_arbiter.sv
// Round-robin bus arbiter: grants one requester per cycle, starting the
// search one past the port that was granted last.
// Assumes: requesters hold their request until granted.
module coh_rr_arbiter #(
    parameter int N = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N-1:0]                 req,
    output logic [N-1:0]                 gnt,
    output logic [((N>1)?$clog2(N):1)-1:0] win,
    output logic                         any
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [PW-1:0] ptr_q;

    // Pick the first requester at or after the priority pointer.
    always_comb begin
        gnt = '0;
        win = '0;
        any = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (!any && req[(int'(ptr_q) + k) % N]) begin
                any = 1'b1;
                win = PW'((int'(ptr_q) + k) % N);
            end
        end
        if (any) gnt[win] = 1'b1;
    end

    // Move the priority pointer past the port just granted.
    always_ff @(posedge clk) begin
        if (!rst_n)   ptr_q <= '0;
        else if (any) ptr_q <= (int'(win) == N - 1) ? '0 : win + 1'b1;
    end

    AST_GNT_ONEHOT:  assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt)); // R7
    AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n) (gnt & ~req) == '0); // R7
endmodule

// File: rtl/coh_mem.sv
// Shared main memory: combinational read at the bus address, write at the
// clock edge when the bus carries a write.
// Assumes: at most one bus transaction per cycle.
module coh_mem #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    // Combinational read of the word the bus points at.
    assign rdata = mem_q[addr];

    // Clear on reset, otherwise take the bus write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    AST_MEM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem_q[$past(addr)] == $past(wdata)); // R2
endmodule

// File: rtl/coh_cache.sv
// Private direct-mapped write-through cache (one word per line) with a
// bus snooper. A read hit answers locally; a miss or a write asks for the bus.
// A peer write seen on the bus either clears or refreshes a matching line,
// and that effect is applied before the local read of the same cycle.
// Assumes: the request decision uses the state before the snoop, so a read
// whose line is cleared this cycle simply retries as a miss next cycle.
module coh_cache
    import coh_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  coh_mode_e     mode,
    input  logic          cpu_valid,
    input  logic          cpu_write,
    input  logic [AW-1:0] cpu_addr,
    output logic          bus_req,
    output logic          rd_hit_done,
    output logic [DW-1:0] rd_hit_data,
    input  logic          bus_vld,
    input  logic          bus_wr,
    input  logic          bus_own,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_data
);
    localparam int LINES = 1 << IW;
    localparam int TW    = AW - IW;

    logic [LINES-1:0] valid_q;
    logic [TW-1:0]    tag_q  [LINES];
    logic [DW-1:0]    data_q [LINES];

    logic [IW-1:0] idx, snp_idx;
    logic [TW-1:0] tag, snp_tag;
    logic          hit_pre, line_match, snp_hit, same_line;

    // Lookup for the local port and for the bus address.
    always_comb begin
        idx         = cpu_addr[IW-1:0];
        tag         = cpu_addr[AW-1:IW];
        snp_idx     = bus_addr[IW-1:0];
        snp_tag     = bus_addr[AW-1:IW];
        hit_pre     = valid_q[idx] && (tag_q[idx] == tag);
        line_match  = valid_q[snp_idx] && (tag_q[snp_idx] == snp_tag);
        snp_hit     = bus_vld && bus_wr && !bus_own && line_match;
        same_line   = snp_hit && hit_pre && (snp_idx == idx);
        bus_req     = cpu_valid && (cpu_write || !hit_pre);
        rd_hit_done = cpu_valid && !cpu_write && hit_pre &&
                      !(same_line && (mode == MODE_INV));
        rd_hit_data = (same_line && (mode == MODE_UPD)) ? bus_data : data_q[idx];
    end

    // Line state: own fill or write-hit first, else apply a peer snoop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < LINES; i++) begin
                tag_q[i]  <= '0;
                data_q[i] <= '0;
            end
        end else if (bus_vld && bus_own) begin
            if (!bus_wr) begin
                valid_q[snp_idx] <= 1'b1;
                tag_q[snp_idx]   <= snp_tag;
                data_q[snp_idx]  <= bus_data;
            end else if (line_match) begin
                data_q[snp_idx]  <= bus_data;
            end
        end else if (snp_hit) begin
            if (mode == MODE_INV) valid_q[snp_idx] <= 1'b0;
            else                  data_q[snp_idx]  <= bus_data;
        end
    end

    AST_INV_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_hit && mode == MODE_INV) |=> !valid_q[$past(snp_idx)]); // R4
    AST_UPD_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_hit && mode == MODE_UPD) |=>
        (valid_q[$past(snp_idx)] && data_q[$past(snp_idx)] == $past(bus_data))); // R5
    AST_FILL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_vld && bus_own && !bus_wr) |=>
        (valid_q[$past(snp_idx)] && tag_q[$past(snp_idx)] == $past(snp_tag))); // R3
    AST_HIT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit_done |-> !bus_req); // R6
endmodule

// File: rtl/coh_subsys.sv
// Four-port shared-memory subsystem: private write-through caches, one
// round-robin arbitrated bus, snoopers and the main memory array.
// A granted transaction completes in its grant cycle; a read hit completes
// in its request cycle. Assumes ports hold each request until req_ready.
module coh_subsys
    import coh_pkg::*;
#(
    parameter int NCORE   = 4,
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 16,
    parameter int INDEX_W = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      mode_upd,
    input  logic [NCORE-1:0]          req_valid,
    input  logic [NCORE-1:0]          req_write,
    input  logic [NCORE*ADDR_W-1:0]   req_addr,
    input  logic [NCORE*DATA_W-1:0]   req_wdata,
    output logic [NCORE-1:0]          req_ready,
    output logic [NCORE*DATA_W-1:0]   rsp_rdata
);
    localparam int CW = (NCORE > 1) ? $clog2(NCORE) : 1;

    coh_mode_e         mode;
    logic [NCORE-1:0]  bus_req, gnt, hit_done;
    logic [CW-1:0]     win;
    logic              bus_vld, bus_wr;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata, mem_rdata, bus_data;
    logic [DATA_W-1:0] hit_data [NCORE];

    // Decode the coherence policy.
    assign mode = mode_upd ? MODE_UPD : MODE_INV;

    coh_rr_arbiter #(.N(NCORE)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(bus_req),
        .gnt(gnt), .win(win), .any(bus_vld)
    );

    // Drive the shared bus from the winning port.
    always_comb begin
        bus_addr  = req_addr[int'(win)*ADDR_W +: ADDR_W];
        bus_wdata = req_wdata[int'(win)*DATA_W +: DATA_W];
        bus_wr    = bus_vld && req_write[win];
        bus_data  = bus_wr ? bus_wdata : mem_rdata;
    end

    coh_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(bus_wr),
        .addr(bus_addr), .wdata(bus_wdata), .rdata(mem_rdata)
    );

    for (genvar i = 0; i < NCORE; i++) begin : g_port
        coh_cache #(.AW(ADDR_W), .DW(DATA_W), .IW(INDEX_W)) u_cache (
            .clk(clk), .rst_n(rst_n), .mode(mode),
            .cpu_valid(req_valid[i]), .cpu_write(req_write[i]),
            .cpu_addr(req_addr[i*ADDR_W +: ADDR_W]),
            .bus_req(bus_req[i]), .rd_hit_done(hit_done[i]),
            .rd_hit_data(hit_data[i]),
            .bus_vld(bus_vld), .bus_wr(bus_wr), .bus_own(gnt[i]),
            .bus_addr(bus_addr), .bus_data(bus_data)
        );

        // Completion and read data: the bus result wins over a local hit.
        assign req_ready[i] = gnt[i] | hit_done[i];
        assign rsp_rdata[i*DATA_W +: DATA_W] = gnt[i] ? mem_rdata : hit_data[i];

        AST_WRITE_OWNS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
            (req_ready[i] && req_write[i]) |-> gnt[i]); // R2
        AST_READY_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            req_ready[i] |-> req_valid[i]); // R7
    end
endmodule

// File: tb/tb_coh_subsys.sv
module tb_coh_subsys;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int MW = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_upd = 1'b0;
    logic [NC-1:0]    req_valid = '0;
    logic [NC-1:0]    req_write = '0;
    logic [NC*AW-1:0] req_addr  = '0;
    logic [NC*DW-1:0] req_wdata = '0;
    wire  [NC-1:0]    req_ready;
    wire  [NC*DW-1:0] rsp_rdata;

    coh_subsys dut (
        .clk(clk), .rst_n(rst_n), .mode_upd(mode_upd),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .rsp_rdata(rsp_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    logic [DW-1:0] ref_mem [MW];
    logic [NC-1:0] pend = '0;
    int            done_at [NC];
    logic [DW-1:0] got [NC];

    typedef struct packed {
        logic [1:0]  core;
        logic        wr;
        logic [5:0]  addr;
        logic [15:0] data;
        logic [15:0] exp;
    } vec_t;

    localparam int NVEC = 18;
    localparam vec_t VEC [NVEC] = '{
        '{2'd0, 1'b0, 6'h05, 16'h0000, 16'h0000},  // R1 cold read
        '{2'd1, 1'b0, 6'h05, 16'h0000, 16'h0000},
        '{2'd0, 1'b1, 6'h05, 16'h1111, 16'h0000},
        '{2'd1, 1'b0, 6'h05, 16'h0000, 16'h1111},  // R4 copy dropped
        '{2'd2, 1'b1, 6'h09, 16'h2222, 16'h0000},  // R9 same index, other tag
        '{2'd0, 1'b0, 6'h05, 16'h0000, 16'h1111},
        '{2'd2, 1'b0, 6'h09, 16'h0000, 16'h2222},
        '{2'd3, 1'b1, 6'h3F, 16'h3333, 16'h0000},
        '{2'd3, 1'b0, 6'h3F, 16'h0000, 16'h3333},
        '{2'd1, 1'b1, 6'h05, 16'h4444, 16'h0000},
        '{2'd0, 1'b0, 6'h05, 16'h0000, 16'h4444},
        '{2'd2, 1'b0, 6'h3F, 16'h0000, 16'h3333},
        '{2'd0, 1'b1, 6'h00, 16'h5555, 16'h0000},
        '{2'd0, 1'b0, 6'h00, 16'h0000, 16'h5555},
        '{2'd1, 1'b0, 6'h00, 16'h0000, 16'h5555},
        '{2'd3, 1'b1, 6'h05, 16'h6666, 16'h0000},
        '{2'd0, 1'b0, 6'h05, 16'h0000, 16'h6666},
        '{2'd1, 1'b0, 6'h05, 16'h0000, 16'h6666}
    };

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic set_op(input int c, input bit wr, input logic [AW-1:0] ad,
                          input logic [DW-1:0] dt);
        req_write[c]          = wr;
        req_addr[c*AW +: AW]  = ad;
        req_wdata[c*DW +: DW] = dt;
        pend[c]               = 1'b1;
    endtask

    // Issue all pending ops together; record completion cycle and read data,
    // applying completed writes to the reference before same-cycle reads.
    task automatic run_ops(input string rq);
        int t;
        logic [NC-1:0] fin;
        t = 0;
        for (int i = 0; i < NC; i++) done_at[i] = -1;
        @(negedge clk);
        req_valid = pend;
        pend = '0;
        while (req_valid != '0) begin
            #1;
            fin = req_valid & req_ready;
            for (int i = 0; i < NC; i++)
                if (fin[i] && req_write[i])
                    ref_mem[req_addr[i*AW +: AW]] = req_wdata[i*DW +: DW];
            for (int i = 0; i < NC; i++) begin
                if (fin[i]) begin
                    done_at[i] = t;
                    got[i] = rsp_rdata[i*DW +: DW];
                    if (!req_write[i])
                        chk(got[i] == ref_mem[req_addr[i*AW +: AW]], rq,
                            "read vs reference", int'(got[i]),
                            int'(ref_mem[req_addr[i*AW +: AW]]));
                end
            end
            @(posedge clk);
            #1;
            req_valid = req_valid & ~fin;
            t++;
            if (t > 200) begin
                chk(1'b0, rq, "request never completed", t, 0);
                req_valid = '0;
            end
            if (req_valid != '0) @(negedge clk);
        end
    endtask

    task automatic scenario(input bit upd, input logic [AW-1:0] b);
        int first;
        string r45;
        r45 = upd ? "R5" : "R4";
        // fill port 1 with X
        set_op(1, 1'b0, b + 1, '0);                  run_ops("R3");
        // R8: peer write and local read of the same line in one cycle
        set_op(0, 1'b1, b + 1, 16'hA000 + 16'(b));
        set_op(1, 1'b0, b + 1, '0);                  run_ops("R8");
        chk(done_at[1] == (upd ? 0 : 1), "R8", "read completion cycle", done_at[1], upd ? 0 : 1);
        chk(got[1] == 16'hA000 + 16'(b), "R8", "read sees new value", int'(got[1]), int'(16'hA000 + 16'(b)));
        // peer write, then rotate priority so port 1 would lose a contest
        set_op(0, 1'b1, b + 1, 16'hB000 + 16'(b));   run_ops(r45);
        set_op(1, 1'b1, b + 2, 16'hC000 + 16'(b));   run_ops("R2");
        set_op(1, 1'b0, b + 1, '0);
        set_op(2, 1'b1, b + 3, 16'hD000 + 16'(b));   run_ops(r45);
        chk(done_at[1] == (upd ? 0 : 1), r45, "reread completion cycle", done_at[1], upd ? 0 : 1);
        chk(got[1] == 16'hB000 + 16'(b), r45, "reread value", int'(got[1]), int'(16'hB000 + 16'(b)));
        // R7: four simultaneous writes complete in rotation order
        first = upd ? 3 : 2;
        for (int c = 0; c < NC; c++) set_op(c, 1'b1, b + 12 + AW'(c), 16'hE000 + 16'(c));
        run_ops("R7");
        for (int c = 0; c < NC; c++)
            chk(done_at[c] == (c - first + NC) % NC, "R7", "grant order", done_at[c], (c - first + NC) % NC);
        // R3: a write miss leaves no line behind
        set_op(2, 1'b1, b + 4, 16'hF000 + 16'(b));   run_ops("R3");
        set_op(2, 1'b0, b + 4, '0);
        set_op(3, 1'b1, b + 8, 16'h1234);            run_ops("R3");
        chk(done_at[2] == 1, "R3", "no-allocate read waits for bus", done_at[2], 1);
        // R9: peer write to same index, different tag, leaves the line alone
        set_op(1, 1'b0, b + 1, '0);                  run_ops("R9");
        set_op(0, 1'b1, b + 5, 16'h5A5A);            run_ops("R9");
        set_op(1, 1'b1, b + 2, 16'h0F0F);            run_ops("R9");
        set_op(1, 1'b0, b + 1, '0);
        set_op(2, 1'b1, b + 3, 16'h7777);            run_ops("R9");
        chk(done_at[1] == 0, "R9", "line kept, read hit", done_at[1], 0);
        // R6: a hit does not wait while a peer holds the bus
        chk(done_at[2] == 0 || done_at[2] == 1, "R6", "peer write completes", done_at[2], 0);
    endtask

    task automatic random_phase(input bit upd, input int batches);
        mode_upd = upd;
        for (int n = 0; n < batches; n++) begin
            for (int c = 0; c < NC; c++)
                if ($urandom_range(9) < 6)
                    set_op(c, 1'($urandom_range(1)), AW'($urandom_range(15)), DW'($urandom()));
            if (pend != '0) run_ops("R10");
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        chk(1'b0, "R10", "watchdog expired", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < MW; i++) ref_mem[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == '0, "R1", "ready idle after reset", int'(req_ready), 0);

        // vector table, invalidate mode
        for (int v = 0; v < NVEC; v++) begin
            set_op(int'(VEC[v].core), VEC[v].wr, VEC[v].addr, VEC[v].data);
            run_ops("R2");
            if (!VEC[v].wr)
                chk(got[VEC[v].core] == VEC[v].exp, "R2", "table read",
                    int'(got[VEC[v].core]), int'(VEC[v].exp));
        end

        random_phase(1'b0, 150);
        @(negedge clk); mode_upd = 1'b0;
        scenario(1'b0, 6'h10);
        random_phase(1'b1, 150);
        @(negedge clk); mode_upd = 1'b1;
        scenario(1'b1, 6'h20);
        random_phase(1'b0, 80);

        // R1: reset clears memory and caches (port 1 held 0x21)
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        for (int i = 0; i < MW; i++) ref_mem[i] = '0;
        set_op(1, 1'b0, 6'h21, '0);  run_ops("R1");
        chk(got[1] == '0, "R1", "cached word cleared", int'(got[1]), 0);
        set_op(3, 1'b0, 6'h3F, '0);  run_ops("R1");
        chk(got[3] == '0, "R1", "memory cleared", int'(got[3]), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule